// File: doc/BRIEF.md
# UART Modem Control and Status with Loopback

This block holds the modem control word and the modem status word of a single UART channel. The CPU writes a five-bit control word that drives the active-low data-terminal-ready, request-to-send and general-purpose OP2 pins. It also sets an internal-only OP1 bit and selects diagnostic loopback. The CPU reads a status word. Its upper nibble shows the present state of the four modem lines: clear-to-send, data-set-ready, ring and carrier-detect. Its lower nibble holds sticky change flags, and a modem-status interrupt request is raised while any flag is set.

The four modem input pins are active low and asynchronous. They pass through a synchronizer of `SYNC_STAGES` flops, which all reset to the inactive level. In loopback the external outputs are parked high and the `loop_sel` output tells the serial path to turn its data back on itself. The modem status lines are then fed from the control bits instead of the pins. Reading the status word clears the change flags, but a change detected in the same cycle is kept. The block only reports clear-to-send; that line does not gate any transfer.

Top module: `modem_ctl_loop`

## Requirements
- R1: After reset the control word reads 0. A write takes effect from the next clock. `ctl_rdata` returns the five stored bits in [4:0] with [7:5] at 0.
- R2: Outside loopback, `dtr_n` is the inverse of control bit 0, so it is high after reset.
- R3: Outside loopback, `rts_n` is the inverse of control bit 1.
- R4: Outside loopback, `op2_n` is the inverse of control bit 3. `irq_drive_en` equals control bit 3 at all times.
- R5: Outside loopback, the status upper nibble is the inverse of the synchronized pins: [4] from `cts_n`, [5] from `dsr_n`, [6] from `ri_n` and [7] from `cd_n`. A pin change appears `SYNC_STAGES` clocks after it is sampled.
- R6: Status bits [0], [1] and [3] are set one clock after the clear-to-send, data-set-ready or carrier-detect line (status [4], [5], [7]) changes in either direction. They stay set until a read.
- R7: Status bit [2] is set only when the ring line (status [6]) falls from 1 to 0, which is `ri_n` returning high. The opposite edge leaves bit [2] unchanged.
- R8: A clock with `sts_rd` high clears all change flags, except those set by a change detected in that same clock.
- R9: `msi_req` is high exactly while at least one change flag (status [3:0]) is set.
- R10: With control bit 4 set, `loop_sel` is 1 and `dtr_n`, `rts_n` and `op2_n` are all high, whatever the other control bits are.
- R11: In loopback, status [4] shows control bit 1, [5] bit 0, [6] bit 2 and [7] bit 3. Pin activity has no effect on the status word.
- R12: Control bit 2 (OP1) drives no pin. Outside loopback it changes neither the outputs nor the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 8 | Write data; bits [4:0] are stored |
| ctl_rdata | output | 8 | Control word readback |
| sts_rd | input | 1 | Status read strobe; clears change flags at the clock |
| sts_rdata | output | 8 | Status word: line states [7:4], change flags [3:0] |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| cd_n | input | 1 | Carrier-detect pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| op2_n | output | 1 | General-purpose OP2 pin, active low |
| loop_sel | output | 1 | Loopback select for the serial path |
| irq_drive_en | output | 1 | Puts the interrupt output in its active mode |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
Each modem pin is toggled on its own, both low and high, so each change flag can be tied to the right line and direction. The ring pin is driven through both edges, which separates the falling-edge rule from a plain change detector. Status reads are issued while a pin change is still passing through the synchronizer, which shows whether a read overlapping a new change keeps that change. Loopback is entered with every control pattern while the pins also toggle; this checks the routing of control bits to status lines, the parked outputs and the flags raised when the loopback mux switches.

// File: rtl/modem_ctl_loop.sv
module modem_ctl_loop #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       sts_rd,
  output logic [7:0] sts_rdata,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       cd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       op2_n,
  output logic       loop_sel,
  output logic       irq_drive_en,
  output logic       msi_req
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [4:0] ctl_q;
  logic [3:0] pin_sync [SYNC_STAGES];
  logic [3:0] line_now, line_q, set_vec, delta_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_wdata[4:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) pin_sync[i] <= 4'hF;
    end else begin
      pin_sync[0] <= {cd_n, ri_n, dsr_n, cts_n};
      for (int i = 1; i < SYNC_STAGES; i++) pin_sync[i] <= pin_sync[i-1];
    end

  // line order {cd, ri, dsr, cts}; loopback feeds {op2, op1, dtr, rts}
  assign line_now = ctl_q[4] ? {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1]}
                             : ~pin_sync[LAST];

  assign set_vec = {line_q[3] ^ line_now[3],
                    line_q[2] & ~line_now[2],
                    line_q[1] ^ line_now[1],
                    line_q[0] ^ line_now[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      line_q  <= '0;
      delta_q <= '0;
    end else begin
      line_q  <= line_now;
      delta_q <= (sts_rd ? 4'b0 : delta_q) | set_vec;
    end

  assign ctl_rdata    = {3'b000, ctl_q};
  assign sts_rdata    = {line_now, delta_q};
  assign loop_sel     = ctl_q[4];
  assign dtr_n        = ctl_q[4] | ~ctl_q[0];
  assign rts_n        = ctl_q[4] | ~ctl_q[1];
  assign op2_n        = ctl_q[4] | ~ctl_q[3];
  assign irq_drive_en = ctl_q[3];
  assign msi_req      = |delta_q;

  assert_ctl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_rdata == {3'b000, $past(ctl_wdata[4:0])});

  assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_rd |=> (delta_q & $past(delta_q)) == $past(delta_q));

  assert_ring_rise_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_q[2] && line_now[2] && !delta_q[2] && !sts_rd) |=> !delta_q[2]);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && set_vec == 4'b0) |=> delta_q == 4'b0);

  assert_msi_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_req) |-> $past(set_vec) != 4'b0);

  assert_loop_parks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_sel) |-> (dtr_n && rts_n && op2_n));
endmodule

// File: tb/modem_ctl_loop_tb_top.sv
module modem_ctl_loop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, sts_rd = 0;
  logic [7:0] ctl_wdata = 0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, cd_n = 1;
  logic [7:0] ctl_rdata, sts_rdata;
  logic dtr_n, rts_n, op2_n, loop_sel, irq_drive_en, msi_req;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_ctl_loop #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .op2_n(op2_n), .loop_sel(loop_sel),
    .irq_drive_en(irq_drive_en), .msi_req(msi_req));

  // behavioural reference
  int m_ctl = 0;
  int m_flags = 0;
  int m_prev_ring = 0, m_prev_cts = 0, m_prev_dsr = 0, m_prev_cd = 0;
  int m_pipe[$];

  function automatic int lvl(int word, int bitpos);
    return (word >> bitpos) & 1;
  endfunction

  // returns {cd, ri, dsr, cts} status levels as an int
  function automatic int m_lines();
    int p, cts, dsr, ri, cd;
    if (lvl(m_ctl, 4) == 1) begin
      cts = lvl(m_ctl, 1); dsr = lvl(m_ctl, 0); ri = lvl(m_ctl, 2); cd = lvl(m_ctl, 3);
    end else begin
      p = m_pipe[SYNC-1];
      cts = 1 - lvl(p, 0); dsr = 1 - lvl(p, 1); ri = 1 - lvl(p, 2); cd = 1 - lvl(p, 3);
    end
    return cd * 8 + ri * 4 + dsr * 2 + cts;
  endfunction

  always @(posedge clk) begin
    int now, f;
    if (!rst_n) begin
      m_ctl = 0; m_flags = 0;
      m_prev_ring = 0; m_prev_cts = 0; m_prev_dsr = 0; m_prev_cd = 0;
      m_pipe = {};
      for (int i = 0; i < SYNC; i++) m_pipe.push_back(15);
    end else begin
      now = m_lines();
      f = sts_rd ? 0 : m_flags;
      if (lvl(now, 0) != m_prev_cts) f = f | 1;
      if (lvl(now, 1) != m_prev_dsr) f = f | 2;
      if (m_prev_ring == 1 && lvl(now, 2) == 0) f = f | 4;
      if (lvl(now, 3) != m_prev_cd) f = f | 8;
      m_flags = f;
      m_prev_cts = lvl(now, 0); m_prev_dsr = lvl(now, 1);
      m_prev_ring = lvl(now, 2); m_prev_cd = lvl(now, 3);
      if (ctl_wr) m_ctl = ctl_wdata & 31;
      m_pipe.push_front(cd_n * 8 + ri_n * 4 + dsr_n * 2 + cts_n);
      void'(m_pipe.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int lp, lines;
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      lp = lvl(m_ctl, 4);
      lines = m_lines();
      chk("R1 ctl_rdata", ctl_rdata, m_ctl);
      chk("R2/R10 dtr_n", dtr_n, lp ? 1 : 1 - lvl(m_ctl, 0));
      chk("R3/R10 rts_n", rts_n, lp ? 1 : 1 - lvl(m_ctl, 1));
      chk("R4/R10 op2_n", op2_n, lp ? 1 : 1 - lvl(m_ctl, 3));
      chk("R4 irq_drive_en", irq_drive_en, lvl(m_ctl, 3));
      chk("R10 loop_sel", loop_sel, lp);
      chk("R5/R11/R12 status lines", sts_rdata[7:4], lines);
      chk("R6 flag cts", sts_rdata[0], lvl(m_flags, 0));
      chk("R6 flag dsr", sts_rdata[1], lvl(m_flags, 1));
      chk("R7 flag ring", sts_rdata[2], lvl(m_flags, 2));
      chk("R6 flag cd", sts_rdata[3], lvl(m_flags, 3));
      chk("R9 msi_req", msi_req, m_flags != 0 ? 1 : 0);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0; ctl_wdata = 8'hE0;
  endtask

  task automatic rd();
    @(negedge clk); sts_rd = 1;
    @(negedge clk); sts_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_errors++; n_checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset readback, explicit
    chk("R1 reset ctl", ctl_rdata, 0);
    chk("R2 reset dtr_n", dtr_n, 1);
    // R2/R3/R4 control patterns; R12 OP1 alone
    wr(8'h01); idle(2); wr(8'h02); idle(2); wr(8'h08); idle(2);
    wr(8'h04); idle(3); wr(8'hEB); idle(2); wr(8'h00); idle(2);
    // R5/R6 single pin toggles, both directions
    cts_n = 0; idle(4); rd(); cts_n = 1; idle(4); rd();
    dsr_n = 0; idle(4); rd(); dsr_n = 1; idle(4); rd();
    cd_n = 0;  idle(4); rd(); cd_n = 1;  idle(4); rd();
    // R7 ring: leading edge then trailing edge
    ri_n = 0; idle(5); rd(); idle(2);
    ri_n = 1; idle(5); rd(); idle(2);
    // R8 read overlapping a change in flight
    cts_n = 0; @(negedge clk); sts_rd = 1; idle(3); sts_rd = 0; idle(2);
    dsr_n = 0; @(negedge clk); @(negedge clk); sts_rd = 1; @(negedge clk); sts_rd = 0; idle(3);
    rd(); cts_n = 1; dsr_n = 1; idle(4); rd(); idle(2);
    // R10/R11 loopback with every control pattern, pins toggling
    for (int v = 0; v < 16; v++) begin
      wr(8'(16 + v));
      cts_n = v[0]; ri_n = v[1]; cd_n = ~v[2]; dsr_n = v[3];
      idle(3);
      if (v % 4 == 3) rd();
    end
    cts_n = 1; dsr_n = 1; ri_n = 1; cd_n = 1;
    wr(8'h1F); idle(2); wr(8'h00); idle(5); rd(); idle(3);
    // reset while flags set, then check again
    cd_n = 0; idle(4);
    rst_n = 0; idle(2); rst_n = 1; idle(5); rd(); cd_n = 1; idle(5); rd(); idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule